// File: doc/BRIEF.md
# Interrupt Mask and Arbitration Unit

This block keeps the two interrupt mask flags of a small 8-bit processor's condition code byte and chooses which pending request the core services at an instruction boundary. One flag gates the active-low, level-sensitive pin interrupt. The other flag gates the ordinary maskable request. Two further sources are never gated: the illegal-opcode trap and the software-interrupt instruction.

When a request is taken, the block emits a one-cycle take pulse. With it come a 2-bit vector index and the return address the stacking sequence must save. The block then waits for the core to report that the condition code byte has been stacked, and updates the mask flags one cycle after that report. Software can lower the pin-interrupt flag once, but can never raise it again. After that, only a pin-interrupt entry or a restore of a stacked condition code byte can set it.

The core outside this block handles instruction decoding, the stacking sequence and the vector fetch.

Top module: `irq_mask_arb`

## Requirements
- R1: After reset the pin-interrupt mask `x_bit` and the maskable mask `i_bit` both read 1, and `take` reads 0.
- R2: A software condition code write (`ccr_wr_stb`) loads `i_bit` from bit 4 of `ccr_wr_data` at the next clock edge.
- R3: A software condition code write can only clear `x_bit`. Bit 6 of `ccr_wr_data` equal to 0 clears it. While `x_bit` is 0, a write with bit 6 equal to 1 leaves `x_bit` at 0.
- R4: When several requests qualify in one boundary cycle, the winner follows a fixed order, and `vec_idx` reports it as follows: illegal opcode = 0, software interrupt = 1, pin interrupt = 2, maskable = 3.
- R5: The pin request (`xirq_n` low) qualifies only while `x_bit` is 0. The maskable request (`irq_req` high) qualifies only while `i_bit` is 0. `illop_stb` and `swi_stb` qualify regardless of either mask.
- R6: Requests are sampled only in cycles with `boundary` high. `take` rises at the clock edge that samples such a cycle, and stays high for exactly one cycle.
- R7: From a take until the mask update that ends it, no further take occurs, whatever requests and boundaries arrive.
- R8: At the clock edge one cycle after the edge that samples `stack_done`, the masks are updated. A pin-interrupt entry sets both `x_bit` and `i_bit`. Any other entry sets `i_bit` and leaves `x_bit` unchanged.
- R9: A restore (`ccr_pull_stb`) loads `x_bit` from bit 6 and `i_bit` from bit 4 of `ccr_pull_data`. It may set `x_bit` to 1.
- R10: With the take pulse, `save_addr` holds `op_addr` for an illegal-opcode entry and `next_addr` for every other entry.
- R11: When updates coincide in one cycle, the entry mask update wins over a restore, and a restore wins over a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xirq_n | input | 1 | Pin interrupt request, level, active low |
| irq_req | input | 1 | Maskable interrupt request, active high |
| illop_stb | input | 1 | Illegal opcode detected |
| swi_stb | input | 1 | Software interrupt instruction decoded |
| boundary | input | 1 | Instruction boundary, requests sampled here |
| op_addr | input | 16 | Address of the first byte of the current opcode |
| next_addr | input | 16 | Address of the next instruction |
| ccr_wr_stb | input | 1 | Software write of the condition code byte |
| ccr_wr_data | input | 8 | Written byte (bit 6 = X, bit 4 = I) |
| ccr_pull_stb | input | 1 | Restore of a stacked condition code byte |
| ccr_pull_data | input | 8 | Pulled byte (bit 6 = X, bit 4 = I) |
| stack_done | input | 1 | The condition code byte has been stacked |
| take | output | 1 | One-cycle pulse: a request has been taken |
| vec_idx | output | 2 | Index of the taken source |
| save_addr | output | 16 | Return address to stack, valid with `take` |
| x_bit | output | 1 | Pin-interrupt mask |
| i_bit | output | 1 | Maskable interrupt mask |

## Verification
Each result has its own latency:
- `take`, `vec_idx` and `save_addr` are due one edge after the boundary cycle.
- Software writes and restores show on the mask outputs one edge after the strobe.
- An entry's mask update shows two edges after `stack_done` is driven: one edge registers the strobe and the next applies it.

The bench drives inputs after a falling edge and reads outputs at the following falling edge. Each read therefore sees exactly the registers loaded at the edge in between. For the entry update, the bench checks both the unchanged masks one cycle after the strobe and the updated masks one cycle later. This confirms the extra cycle of delay.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int CCR_W  = 8;
    localparam int X_POS  = 6;
    localparam int I_POS  = 4;
    localparam int NSRC   = 4;
    localparam int VEC_W  = $clog2(NSRC);

    typedef enum logic [VEC_W-1:0] {
        SRC_ILLOP = 2'd0,
        SRC_SWI   = 2'd1,
        SRC_XIRQ  = 2'd2,
        SRC_IRQ   = 2'd3
    } src_e;

    typedef struct packed {
        logic x;
        logic i;
    } mask_t;

    // raw request lines, already converted to active-high
    typedef struct packed {
        logic irq;
        logic xirq;
        logic swi;
        logic illop;
    } req_t;

    function automatic mask_t ccr_to_mask(input logic [CCR_W-1:0] d);
        mask_t m;
        m.x = d[X_POS];
        m.i = d[I_POS];
        return m;
    endfunction

endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_arb_pkg::*;
(
    input  req_t  req,
    input  mask_t mask,
    output logic  sel_valid,
    output src_e  sel_src
);

    logic [NSRC-1:0] qual;

    always_comb begin
        qual                 = '0;
        qual[int'(SRC_ILLOP)] = req.illop;
        qual[int'(SRC_SWI)]   = req.swi;
        qual[int'(SRC_XIRQ)]  = req.xirq & ~mask.x;
        qual[int'(SRC_IRQ)]   = req.irq & ~mask.i;
    end

    // lowest index wins: scan from the top so the last hit is the winner
    always_comb begin
        sel_valid = 1'b0;
        sel_src   = SRC_IRQ;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (qual[k]) begin
                sel_valid = 1'b1;
                sel_src   = src_e'(k[VEC_W-1:0]);
            end
        end
    end

endmodule

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl
    import irq_arb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  logic              sel_valid,
    input  src_e              sel_src,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic              stack_done,
    output logic              take,
    output src_e              vec,
    output logic [ADDR_W-1:0] save_addr,
    output logic              busy,
    output logic              upd_set_x,
    output logic              upd_set_i
);

    src_e kind;
    logic upd_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            take      <= 1'b0;
            vec       <= SRC_ILLOP;
            kind      <= SRC_ILLOP;
            save_addr <= '0;
            busy      <= 1'b0;
            upd_pend  <= 1'b0;
        end else begin
            take     <= 1'b0;
            upd_pend <= busy & stack_done & ~upd_pend;
            if (!busy && boundary && sel_valid) begin
                take      <= 1'b1;
                vec       <= sel_src;
                kind      <= sel_src;
                busy      <= 1'b1;
                save_addr <= (sel_src == SRC_ILLOP) ? op_addr : next_addr;
            end else if (upd_pend) begin
                busy <= 1'b0;
            end
        end
    end

    assign upd_set_i = upd_pend;
    assign upd_set_x = upd_pend & (kind == SRC_XIRQ);

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
    import irq_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_set_x,
    input  logic             upd_set_i,
    input  logic             pull_stb,
    input  logic [CCR_W-1:0] pull_data,
    input  logic             wr_stb,
    input  logic [CCR_W-1:0] wr_data,
    output mask_t            mask
);

    mask_t pull_m;
    mask_t wr_m;
    logic  unused_ccr_bits;

    assign pull_m          = ccr_to_mask(pull_data);
    assign wr_m            = ccr_to_mask(wr_data);
    assign unused_ccr_bits = ^{pull_data, wr_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '{x: 1'b1, i: 1'b1};
        end else if (upd_set_i) begin
            mask.i <= 1'b1;
            if (upd_set_x) mask.x <= 1'b1;
        end else if (pull_stb) begin
            mask <= pull_m;
        end else if (wr_stb) begin
            mask.x <= mask.x & wr_m.x;
            mask.i <= wr_m.i;
        end
    end

endmodule

// File: rtl/irq_mask_arb.sv
module irq_mask_arb
    import irq_arb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xirq_n,
    input  logic              irq_req,
    input  logic              illop_stb,
    input  logic              swi_stb,
    input  logic              boundary,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic              ccr_wr_stb,
    input  logic [CCR_W-1:0]  ccr_wr_data,
    input  logic              ccr_pull_stb,
    input  logic [CCR_W-1:0]  ccr_pull_data,
    input  logic              stack_done,
    output logic              take,
    output logic [VEC_W-1:0]  vec_idx,
    output logic [ADDR_W-1:0] save_addr,
    output logic              x_bit,
    output logic              i_bit
);

    req_t  req;
    mask_t mask;
    logic  sel_valid;
    src_e  sel_src;
    src_e  vec;
    logic  busy;
    logic  upd_set_x;
    logic  upd_set_i;

    assign req = '{irq: irq_req, xirq: ~xirq_n, swi: swi_stb, illop: illop_stb};

    irq_prio_sel u_sel (
        .req       (req),
        .mask      (mask),
        .sel_valid (sel_valid),
        .sel_src   (sel_src)
    );

    irq_entry_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .boundary  (boundary),
        .sel_valid (sel_valid),
        .sel_src   (sel_src),
        .op_addr   (op_addr),
        .next_addr (next_addr),
        .stack_done(stack_done),
        .take      (take),
        .vec       (vec),
        .save_addr (save_addr),
        .busy      (busy),
        .upd_set_x (upd_set_x),
        .upd_set_i (upd_set_i)
    );

    irq_mask_regs u_msk (
        .clk       (clk),
        .rst       (rst),
        .upd_set_x (upd_set_x),
        .upd_set_i (upd_set_i),
        .pull_stb  (ccr_pull_stb),
        .pull_data (ccr_pull_data),
        .wr_stb    (ccr_wr_stb),
        .wr_data   (ccr_wr_data),
        .mask      (mask)
    );

    assign vec_idx = vec;
    assign x_bit   = mask.x;
    assign i_bit   = mask.i;

endmodule

// File: rtl/irq_mask_arb_chk.sv
module irq_mask_arb_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              xirq_n,
    input logic              irq_req,
    input logic              boundary,
    input logic [ADDR_W-1:0] op_addr,
    input logic              ccr_pull_stb,
    input logic              take,
    input logic [1:0]        vec_idx,
    input logic [ADDR_W-1:0] save_addr,
    input logic              x_bit,
    input logic              i_bit,
    input logic              busy,
    input logic              upd_set_x,
    input logic              upd_set_i
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (x_bit && i_bit && !take));

    // R3
    x_raise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(x_bit) |-> ($past(ccr_pull_stb) || $past(upd_set_x)));

    // R6
    take_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    // R6
    take_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(boundary));

    // R7
    no_take_busy_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> !$past(busy));

    // R5
    xirq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (take && vec_idx == 2'd2) |-> $past(!x_bit && !xirq_n));

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (take && vec_idx == 2'd3) |-> $past(!i_bit && irq_req));

    // R10
    illop_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (take && vec_idx == 2'd0) |-> (save_addr == $past(op_addr)));

    // R8
    mask_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_set_i && !upd_set_x) |=> (i_bit && x_bit == $past(x_bit)));

    // R8
    xirq_entry_chk: assert property (@(posedge clk) disable iff (rst)
        upd_set_x |=> (i_bit && x_bit));

endmodule

bind irq_mask_arb irq_mask_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .xirq_n       (xirq_n),
    .irq_req      (irq_req),
    .boundary     (boundary),
    .op_addr      (op_addr),
    .ccr_pull_stb (ccr_pull_stb),
    .take         (take),
    .vec_idx      (vec_idx),
    .save_addr    (save_addr),
    .x_bit        (x_bit),
    .i_bit        (i_bit),
    .busy         (busy),
    .upd_set_x    (upd_set_x),
    .upd_set_i    (upd_set_i)
);

// File: tb/tb_irq_mask_arb.sv
module tb_irq_mask_arb;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          xirq_n = 1'b1;
    logic          irq_req = 1'b0;
    logic          illop_stb = 1'b0;
    logic          swi_stb = 1'b0;
    logic          boundary = 1'b0;
    logic [AW-1:0] op_addr = 16'h0100;
    logic [AW-1:0] next_addr = 16'h0102;
    logic          ccr_wr_stb = 1'b0;
    logic [7:0]    ccr_wr_data = 8'h00;
    logic          ccr_pull_stb = 1'b0;
    logic [7:0]    ccr_pull_data = 8'h00;
    logic          stack_done = 1'b0;
    logic          take;
    logic [1:0]    vec_idx;
    logic [AW-1:0] save_addr;
    logic          x_bit;
    logic          i_bit;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_mask_arb #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .xirq_n(xirq_n), .irq_req(irq_req),
        .illop_stb(illop_stb), .swi_stb(swi_stb), .boundary(boundary),
        .op_addr(op_addr), .next_addr(next_addr),
        .ccr_wr_stb(ccr_wr_stb), .ccr_wr_data(ccr_wr_data),
        .ccr_pull_stb(ccr_pull_stb), .ccr_pull_data(ccr_pull_data),
        .stack_done(stack_done), .take(take), .vec_idx(vec_idx),
        .save_addr(save_addr), .x_bit(x_bit), .i_bit(i_bit)
    );

    // {illop, swi, xirq request, irq, x, i, expect take, expect vec[1:0]}
    localparam int NV = 12;
    localparam logic [8:0] VECS [NV] = '{
        9'b1111_00_1_00, 9'b0111_00_1_01, 9'b0011_00_1_10, 9'b0001_00_1_11,
        9'b0011_10_1_11, 9'b0010_11_0_00, 9'b0001_01_0_00, 9'b1000_11_1_00,
        9'b0100_11_1_01, 9'b0011_01_1_10, 9'b0000_00_0_00, 9'b0010_00_1_10
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_mask(input logic x, input logic i);
        ccr_pull_stb  = 1'b1;
        ccr_pull_data = {1'b0, x, 1'b0, i, 4'b0};
        step();
        ccr_pull_stb  = 1'b0;
    endtask

    task automatic serve();
        stack_done = 1'b1;
        step();
        stack_done = 1'b0;
        step();
    endtask

    task automatic drive_req(input logic il, input logic sw, input logic xr, input logic ir);
        illop_stb = il;
        swi_stb   = sw;
        xirq_n    = ~xr;
        irq_req   = ir;
        boundary  = 1'b1;
        step();
        illop_stb = 1'b0;
        swi_stb   = 1'b0;
        xirq_n    = 1'b1;
        irq_req   = 1'b0;
        boundary  = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step();
        step();
        rst = 1'b0;
        // R1 reset state
        chk("R1 x", x_bit, 1);
        chk("R1 i", i_bit, 1);
        chk("R1 take", take, 0);

        // vector table: R4 priority, R5 gating
        for (int n = 0; n < NV; n++) begin
            logic [8:0] v;
            v = VECS[n];
            set_mask(v[4], v[3]);
            drive_req(v[8], v[7], v[6], v[5]);
            chk("R5 take", take, v[2]);
            if (v[2]) begin
                chk("R4 vec", vec_idx, v[1:0]);
                serve();
            end
        end

        // R9 restore, R2 and R3 software writes
        set_mask(0, 0);
        chk("R9 x", x_bit, 0);
        chk("R9 i", i_bit, 0);
        ccr_wr_stb = 1'b1; ccr_wr_data = 8'h50; step(); ccr_wr_stb = 1'b0;
        chk("R3 x stays clear", x_bit, 0);
        chk("R2 i set", i_bit, 1);
        ccr_wr_stb = 1'b1; ccr_wr_data = 8'h00; step(); ccr_wr_stb = 1'b0;
        chk("R2 i clear", i_bit, 0);
        set_mask(1, 0);
        chk("R9 x raised", x_bit, 1);
        ccr_wr_stb = 1'b1; ccr_wr_data = 8'h00; step(); ccr_wr_stb = 1'b0;
        chk("R3 x cleared", x_bit, 0);

        // R6 no boundary, no take
        set_mask(0, 0);
        irq_req = 1'b1;
        step();
        chk("R6 no boundary", take, 0);
        step();
        chk("R6 no boundary again", take, 0);
        irq_req = 1'b0;

        // R6 pulse width and R7 busy blocking
        drive_req(1, 0, 0, 0);
        chk("R6 take", take, 1);
        drive_req(0, 1, 0, 0);
        chk("R6 pulse", take, 0);
        drive_req(0, 1, 0, 0);
        chk("R7 busy", take, 0);
        serve();
        drive_req(0, 1, 0, 0);
        chk("R7 released", take, 1);
        chk("R7 vec", vec_idx, 1);
        serve();

        // R8 pin entry sets both, one cycle after stack_done
        set_mask(0, 0);
        drive_req(0, 0, 1, 0);
        chk("R8 take", take, 1);
        stack_done = 1'b1; step(); stack_done = 1'b0;
        chk("R8 x not yet", x_bit, 0);
        chk("R8 i not yet", i_bit, 0);
        step();
        chk("R8 x set", x_bit, 1);
        chk("R8 i set", i_bit, 1);

        // R8 maskable entry sets I only
        set_mask(0, 0);
        drive_req(0, 0, 0, 1);
        chk("R8 irq take", take, 1);
        serve();
        chk("R8 x kept", x_bit, 0);
        chk("R8 i set irq", i_bit, 1);

        // R10 saved address
        op_addr = 16'h1234;
        next_addr = 16'h1236;
        drive_req(1, 0, 0, 0);
        chk("R10 illop addr", save_addr, 16'h1234);
        serve();
        drive_req(0, 1, 0, 0);
        chk("R10 swi addr", save_addr, 16'h1236);
        serve();

        // R11 entry update beats restore, restore beats write
        set_mask(0, 0);
        drive_req(0, 0, 1, 0);
        stack_done = 1'b1; step(); stack_done = 1'b0;
        ccr_pull_stb = 1'b1; ccr_pull_data = 8'h00; step(); ccr_pull_stb = 1'b0;
        chk("R11 entry wins x", x_bit, 1);
        chk("R11 entry wins i", i_bit, 1);
        ccr_pull_stb = 1'b1; ccr_pull_data = 8'h40;
        ccr_wr_stb = 1'b1; ccr_wr_data = 8'h10;
        step();
        ccr_pull_stb = 1'b0; ccr_wr_stb = 1'b0;
        chk("R11 restore wins x", x_bit, 1);
        chk("R11 restore wins i", i_bit, 0);

        // R1 reset during operation
        set_mask(0, 0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R1 rerst x", x_bit, 1);
        chk("R1 rerst i", i_bit, 1);
        chk("R1 rerst take", take, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule